// File: doc/BRIEF.md
# UART FIFO Interrupt Controller

This block produces the single interrupt request of a UART whose receive and transmit FIFOs are 16 entries deep. The datapath reports the fill count of each FIFO, strobes for every character pushed into or popped from the receive FIFO, a pulse when a received character had no room, a pulse once per character time, and a level that summarises pending modem-line events. The controller turns these into six interrupt sources. Each source has a live status bit and an enable bit, and both sit in the same register word. The interrupt line is high whenever any source has both its status bit and its enable bit set.

Software reaches the controller through a plain register port. Writes take effect on the clock edge, and reads are combinational from the address. The port holds the two fill thresholds, the receive timeout in character times and the enable bits. It also shows the current transmit fill count, so a driver can write up to depth minus fill characters without overflowing the FIFO. A read-only receive-not-empty flag lets a driver drain the FIFO until that flag clears. The data path gives a strobe for each read of the FIFO data register, and that strobe clears a sticky overrun.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the enable bits are 0, both thresholds are 8 (word 1 reads 0x0808), the timeout count is 1 (word 2 reads 1), the overrun status is clear and `irq` is low.
- R2: `irq` equals the OR, over the six sources, of status AND enable. In word 0, enable bits sit at [5:0] and status bits at [13:8], in the same source order: 0 overrun, 1 receive at or above threshold, 2 receive timeout, 3 transmit empty, 4 transmit below threshold, 5 external input.
- R3: Receive-threshold status (word 0 bit 9) is 1 exactly when `rx_fill` is greater than or equal to the receive threshold (word 1 bits [4:0]).
- R4: Overrun status (bit 8) is set in the cycle after an `rx_overrun` pulse. It holds until a `data_rd` strobe, which clears it in the following cycle. If `rx_overrun` and `data_rd` come in the same cycle, the status ends up set.
- R5: The timeout counter restarts on any `rx_push` or `rx_pop` and while `rx_fill` is 0. Otherwise it advances on each `char_tick`. Timeout status (bit 10) is 1 once the count reaches the value in word 2 bits [3:0] while the FIFO is not empty. A push in the same cycle as a tick restarts the count.
- R6: Transmit-empty status (bit 11) is 1 exactly when `tx_fill` is 0. Transmit-below status (bit 12) is 1 exactly when `tx_fill` is less than the transmit threshold (word 1 bits [12:8]).
- R7: Word 0 bit 14 reads 1 exactly when `rx_fill` is nonzero. This bit never drives `irq`.
- R8: Word 3 bits [4:0] read the current `tx_fill`.
- R9: External status (bit 13) follows `ext_event`.
- R10: A write to word 0 changes only the enable bits and has no effect on any status bit. A write to word 3 changes nothing.
- R11: A timeout count of 0 keeps the timeout status at 0, however many character ticks pass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| rx_fill | input | 5 | Receive FIFO occupancy, 0 to 16 |
| rx_push | input | 1 | A character entered the receive FIFO |
| rx_pop | input | 1 | A character left the receive FIFO |
| rx_overrun | input | 1 | A received character found the FIFO full |
| data_rd | input | 1 | Software read the FIFO data register |
| char_tick | input | 1 | One pulse per character time |
| tx_fill | input | 5 | Transmit FIFO occupancy, 0 to 16 |
| ext_event | input | 1 | Enabled modem-line event pending |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of events can land on the same clock edge. An overrun pulse can coincide with the data-register read that would clear it. A push into the receive FIFO can coincide with the character tick that would advance the timeout. The bench drives each pair together on one edge. It judges the outcome from word 0 on the next cycle: the overrun must still be set, and the timeout must have restarted, so it takes the full programmed number of further ticks before it fires. The threshold compares and the enable gating are swept over every value of a 16-deep configuration.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int NSRC     = 6;
  localparam int SRC_OVR  = 0;
  localparam int SRC_RXTH = 1;
  localparam int SRC_TMO  = 2;
  localparam int SRC_TXE  = 3;
  localparam int SRC_TXLO = 4;
  localparam int SRC_EXT  = 5;
  localparam int STAT_LSB = 8;
  localparam int RXNE_BIT = 14;
  localparam int TXTH_LSB = 8;
  localparam logic [1:0] W_IRQ  = 2'd0;
  localparam logic [1:0] W_THR  = 2'd1;
  localparam logic [1:0] W_TMO  = 2'd2;
  localparam logic [1:0] W_TXLV = 2'd3;
endpackage

// File: rtl/uirq_regs.sv
module uirq_regs
  import uirq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int FILL_W = $clog2(DEPTH + 1),
  parameter int TMO_W  = 4,
  parameter int DW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  input  logic [NSRC-1:0]   stat,
  input  logic              rx_ne,
  input  logic [FILL_W-1:0] tx_fill,
  output logic [NSRC-1:0]   mask,
  output logic [FILL_W-1:0] rx_thr,
  output logic [FILL_W-1:0] tx_thr,
  output logic [TMO_W-1:0]  tmo,
  output logic [DW-1:0]     reg_rdata
);
  localparam logic [FILL_W-1:0] THR_RST = FILL_W'(DEPTH / 2);
  localparam logic [TMO_W-1:0]  TMO_RST = TMO_W'(1);

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask   <= '0;
      rx_thr <= THR_RST;
      tx_thr <= THR_RST;
      tmo    <= TMO_RST;
    end else if (reg_wr) begin
      case (reg_addr)
        W_IRQ: mask <= reg_wdata[NSRC-1:0];
        W_THR: begin
          rx_thr <= reg_wdata[FILL_W-1:0];
          tx_thr <= reg_wdata[TXTH_LSB +: FILL_W];
        end
        W_TMO:   tmo <= reg_wdata[TMO_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      W_IRQ: begin
        reg_rdata[NSRC-1:0]          = mask;
        reg_rdata[STAT_LSB +: NSRC]  = stat;
        reg_rdata[RXNE_BIT]          = rx_ne;
      end
      W_THR: begin
        reg_rdata[FILL_W-1:0]        = rx_thr;
        reg_rdata[TXTH_LSB +: FILL_W] = tx_thr;
      end
      W_TMO:   reg_rdata[TMO_W-1:0]  = tmo;
      default: reg_rdata[FILL_W-1:0] = tx_fill;
    endcase
  end

  // R10: a write to the read-only word leaves the thresholds alone
  p_txlv_ro_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == W_TXLV) |=> ($stable(rx_thr) && $stable(tx_thr) && $stable(tmo)));
  // R10: the enable bits move only on a write to word 0
  p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == W_IRQ) |=> $stable(mask));
endmodule

// File: rtl/uirq_rx_timeout.sv
module uirq_rx_timeout #(
  parameter int TMO_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_empty,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic             char_tick,
  input  logic [TMO_W-1:0] tmo,
  output logic             expired
);
  localparam logic [TMO_W-1:0] CNT_MAX = '1;

  logic [TMO_W-1:0] cnt;
  logic             restart;

  assign restart = rx_push | rx_pop | rx_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt <= '0;
    else if (restart)                    cnt <= '0;
    else if (char_tick && cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  assign expired = (tmo != '0) && (cnt >= tmo) && !rx_empty;

  // R5: activity restarts the count, so the timeout cannot be up next cycle
  p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push || rx_pop) |=> !expired);
  // R5: an empty FIFO never reports a timeout
  p_empty_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty |-> !expired);
  // R11: a zero count disables the source
  p_zero_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo == '0) |-> !expired);
endmodule

// File: rtl/uirq_src.sv
module uirq_src
  import uirq_pkg::*;
#(
  parameter int FILL_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FILL_W-1:0] rx_fill,
  input  logic [FILL_W-1:0] tx_fill,
  input  logic [FILL_W-1:0] rx_thr,
  input  logic [FILL_W-1:0] tx_thr,
  input  logic              rx_overrun,
  input  logic              data_rd,
  input  logic              tmo_exp,
  input  logic              ext_event,
  input  logic [NSRC-1:0]   mask,
  output logic [NSRC-1:0]   stat,
  output logic              rx_ne,
  output logic              irq
);
  logic            ovr_q;
  logic [NSRC-1:0] hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ovr_q <= 1'b0;
    else if (rx_overrun) ovr_q <= 1'b1;
    else if (data_rd)    ovr_q <= 1'b0;
  end

  always_comb begin
    stat           = '0;
    stat[SRC_OVR]  = ovr_q;
    stat[SRC_RXTH] = (rx_fill >= rx_thr);
    stat[SRC_TMO]  = tmo_exp;
    stat[SRC_TXE]  = (tx_fill == '0);
    stat[SRC_TXLO] = (tx_fill < tx_thr);
    stat[SRC_EXT]  = ext_event;
  end

  assign rx_ne = (rx_fill != '0);

  for (genvar g = 0; g < NSRC; g++) begin : g_gate
    assign hit[g] = stat[g] & mask[g];
  end

  assign irq = |hit;

  // R4: an overrun pulse always leaves the status set
  p_ovr_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |=> stat[SRC_OVR]);
  // R4: without a data read the status is sticky
  p_ovr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[SRC_OVR] && !data_rd) |=> stat[SRC_OVR]);
  // R2: no enabled source means no request
  p_irq_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);
  // R6: an empty transmit FIFO is below any nonzero threshold
  p_txe_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((tx_fill == '0) && (tx_thr != '0)) |-> (stat[SRC_TXE] && stat[SRC_TXLO]));
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uirq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int FILL_W = $clog2(DEPTH + 1),
  parameter int TMO_W  = 4,
  parameter int DW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FILL_W-1:0] rx_fill,
  input  logic              rx_push,
  input  logic              rx_pop,
  input  logic              rx_overrun,
  input  logic              data_rd,
  input  logic              char_tick,
  input  logic [FILL_W-1:0] tx_fill,
  input  logic              ext_event,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq
);
  logic [NSRC-1:0]   mask;
  logic [NSRC-1:0]   stat;
  logic [FILL_W-1:0] rx_thr;
  logic [FILL_W-1:0] tx_thr;
  logic [TMO_W-1:0]  tmo;
  logic              rx_ne;
  logic              tmo_exp;

  uirq_regs #(.DEPTH(DEPTH), .FILL_W(FILL_W), .TMO_W(TMO_W), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .stat(stat), .rx_ne(rx_ne), .tx_fill(tx_fill),
    .mask(mask), .rx_thr(rx_thr), .tx_thr(tx_thr), .tmo(tmo),
    .reg_rdata(reg_rdata)
  );

  uirq_rx_timeout #(.TMO_W(TMO_W)) u_tmo (
    .clk(clk), .rst_n(rst_n), .rx_empty(!rx_ne), .rx_push(rx_push),
    .rx_pop(rx_pop), .char_tick(char_tick), .tmo(tmo), .expired(tmo_exp)
  );

  uirq_src #(.FILL_W(FILL_W)) u_src (
    .clk(clk), .rst_n(rst_n), .rx_fill(rx_fill), .tx_fill(tx_fill),
    .rx_thr(rx_thr), .tx_thr(tx_thr), .rx_overrun(rx_overrun),
    .data_rd(data_rd), .tmo_exp(tmo_exp), .ext_event(ext_event),
    .mask(mask), .stat(stat), .rx_ne(rx_ne), .irq(irq)
  );

  // R7: the not-empty flag appears on the status word with any occupancy
  p_rxne_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == W_IRQ && rx_fill != '0) |-> reg_rdata[RXNE_BIT]);
  // R8: the read-only word mirrors the transmit occupancy
  p_txlv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == W_TXLV) |-> (reg_rdata[FILL_W-1:0] == tx_fill));
endmodule

// File: tb/test_uart_irq_ctrl.sv
module test_uart_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  rx_fill = '0;
  logic        rx_push = 1'b0;
  logic        rx_pop = 1'b0;
  logic        rx_overrun = 1'b0;
  logic        data_rd = 1'b0;
  logic        char_tick = 1'b0;
  logic [4:0]  tx_fill = '0;
  logic        ext_event = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  uart_irq_ctrl i_uart_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_fill(rx_fill), .rx_push(rx_push),
    .rx_pop(rx_pop), .rx_overrun(rx_overrun), .data_rd(data_rd),
    .char_tick(char_tick), .tx_fill(tx_fill), .ext_event(ext_event),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input bit p, input bit t, input bit o, input bit r);
    @(negedge clk);
    rx_push = p; char_tick = t; rx_overrun = o; data_rd = r;
    @(negedge clk);
    rx_push = 1'b0; char_tick = 1'b0; rx_overrun = 1'b0; data_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [5:0]  st;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #1 check("R1 irq", irq, 0);
    rd(2'd0, d); check("R1 word0", d, 16'h1800);
    rd(2'd1, d); check("R1 thresholds", d, 16'h0808);
    rd(2'd2, d); check("R1 timeout", d, 16'h0001);

    // R3 / R7 sweep of receive threshold against fill
    for (int th = 0; th <= 16; th++) begin
      wr(2'd1, 16'((8 << 8) | th));
      for (int f = 0; f <= 16; f++) begin
        rx_fill = 5'(f);
        rd(2'd0, d);
        check("R3 rx threshold", d[9], (f >= th));
        check("R7 rx not empty", d[14], (f != 0));
      end
    end
    rx_fill = '0;

    // R6 / R8 sweep of transmit threshold against fill
    for (int th = 0; th <= 16; th++) begin
      wr(2'd1, 16'((th << 8) | 8));
      for (int f = 0; f <= 16; f++) begin
        tx_fill = 5'(f);
        rd(2'd0, d);
        check("R6 tx empty", d[11], (f == 0));
        check("R6 tx below", d[12], (f < th));
        rd(2'd3, d);
        check("R8 tx level", d, 16'(f));
      end
    end
    wr(2'd1, 16'h0808);

    // R2 enable gating over every mask and four input patterns
    for (int p = 0; p < 4; p++) begin
      case (p)
        0: begin rx_fill = 5'd0; tx_fill = 5'd16; ext_event = 1'b0; st = 6'b000000; end
        1: begin rx_fill = 5'd8; tx_fill = 5'd16; ext_event = 1'b0; st = 6'b000010; end
        2: begin rx_fill = 5'd0; tx_fill = 5'd0;  ext_event = 1'b0; st = 6'b011000; end
        default: begin rx_fill = 5'd0; tx_fill = 5'd4; ext_event = 1'b1; st = 6'b110000; end
      endcase
      for (int m = 0; m < 64; m++) begin
        wr(2'd0, 16'(m));
        rd(2'd0, d);
        check("R2 status", d[13:8], st);
        check("R2 irq", irq, |(st & 6'(m)));
      end
    end
    wr(2'd0, 16'h0000);

    // R9 external input
    tx_fill = 5'd16; ext_event = 1'b1;
    rd(2'd0, d); check("R9 ext set", d[13], 1);
    ext_event = 1'b0;
    rd(2'd0, d); check("R9 ext clear", d[13], 0);

    // R4 sticky overrun, cleared by data read, set wins on collision
    wr(2'd0, 16'h0001);
    pulse(0, 0, 1, 0);
    rd(2'd0, d); check("R4 overrun set", d[8], 1);
    check("R4 irq on overrun", irq, 1);
    repeat (5) @(negedge clk);
    rd(2'd0, d); check("R4 overrun held", d[8], 1);
    pulse(0, 0, 0, 1);
    rd(2'd0, d); check("R4 overrun cleared", d[8], 0);
    check("R4 irq cleared", irq, 0);
    pulse(0, 0, 1, 1);
    rd(2'd0, d); check("R4 collision keeps set", d[8], 1);
    pulse(0, 0, 0, 1);
    rd(2'd0, d); check("R4 clear again", d[8], 0);

    // R5 timeout of three character times
    wr(2'd2, 16'd3);
    wr(2'd0, 16'h0004);
    rx_fill = 5'd1;
    pulse(1, 0, 0, 0);
    pulse(0, 1, 0, 0);
    pulse(0, 1, 0, 0);
    rd(2'd0, d); check("R5 two ticks", d[10], 0);
    pulse(0, 1, 0, 0);
    rd(2'd0, d); check("R5 three ticks", d[10], 1);
    check("R5 irq", irq, 1);
    pulse(1, 1, 0, 0);
    rd(2'd0, d); check("R5 push with tick restarts", d[10], 0);
    pulse(0, 1, 0, 0);
    pulse(0, 1, 0, 0);
    rd(2'd0, d); check("R5 restart two ticks", d[10], 0);
    pulse(0, 1, 0, 0);
    rd(2'd0, d); check("R5 restart three ticks", d[10], 1);
    rx_fill = 5'd0;
    rd(2'd0, d); check("R5 empty clears", d[10], 0);

    // R5 one character time
    wr(2'd2, 16'd1);
    rx_fill = 5'd2;
    pulse(1, 0, 0, 0);
    rd(2'd0, d); check("R5 no tick yet", d[10], 0);
    pulse(0, 1, 0, 0);
    rd(2'd0, d); check("R5 one tick", d[10], 1);

    // R11 zero count disables
    wr(2'd2, 16'd0);
    for (int k = 0; k < 20; k++) pulse(0, 1, 0, 0);
    rd(2'd0, d); check("R11 disabled", d[10], 0);
    rx_fill = 5'd0;

    // R10 writes do not reach status or read-only state
    tx_fill = 5'd3;
    wr(2'd0, 16'hFFC0);
    rd(2'd0, d); check("R10 word0", d, 16'h1000);
    check("R10 irq", irq, 0);
    wr(2'd3, 16'hFFFF);
    rd(2'd3, d); check("R10 tx level", d, 16'd3);
    rd(2'd1, d); check("R10 thresholds", d, 16'h0808);
    rd(2'd2, d); check("R10 timeout", d, 16'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule